// File: doc/BRIEF.md
# Codec Sample Clock Generator

This block derives two timing references for a voice codec from a fast master clock: an internal clock enable and a frame-rate strobe. The internal clock is not a separate clock. It is a one-cycle enable pulse. A two-bit prescaler setting makes it fire on every master cycle, on every second cycle or on every fourth cycle, or stops it entirely for shutdown. The frame strobe (`lrclk`) is a square-ish wave at the sample rate. A single-cycle `frame_start` pulse marks the rising edge of `lrclk`.

The sample rate comes from one of two sources. In the exact-integer modes, the internal clock is divided by a fixed ratio. Each ratio suits one of three internal clock frequencies (12 MHz, 13 MHz and 19.2 MHz) and gives exactly 8 kHz or 16 kHz. The 13 MHz case at 16 kHz needs a ratio of 812.5. The block realises it with alternating frames of 812 and 813 internal clocks. In normal mode, a 15-bit coefficient is added into a 16-bit phase accumulator on every internal clock. Each carry out starts a frame, which gives a rate of coef/65536 of the internal clock.

Mode, rate and coefficient changes are applied only at frame boundaries. The control FSM has three states:
- `ST_IDLE`: stopped or waiting for the first internal clock.
- `ST_EXACT`: a fixed-ratio counter is running.
- `ST_NORMAL`: the accumulator is running.

The FSM has these transitions:
- IDLE→EXACT or IDLE→NORMAL on the first enable after leaving shutdown.
- EXACT or NORMAL→EXACT or NORMAL at every frame boundary, chosen by the live mode field.
- Any state→IDLE while the prescaler setting is 00.

Top module: `codec_frame_clkgen`

## Requirements
- R1: The `pclk_en` output follows `presc_sel`. With 01 it is high on every master cycle. With 10 it is high on every second cycle, and with 11 on every fourth cycle. Counting starts at 0 on the cycle the setting leaves 00, and the enable is high when the phase count is 1 (for 10) or 3 (for 11). With 00 it stays low.
- R2: While `presc_sel` is 00, from the next cycle on `lrclk` and `frame_start` are low and all counters are cleared. On the first enable after leaving 00, a new frame starts and `frame_start` rises one cycle later.
- R3: With `freq_mode` 01, a frame lasts 1500 internal clocks when `rate_hi` is 0 and 750 when it is 1.
- R4: With `freq_mode` 10, a frame lasts 1625 internal clocks when `rate_hi` is 0. When `rate_hi` is 1, frames alternate 812, 813, 812, … with the first frame after a setting change being 812.
- R5: With `freq_mode` 11, a frame lasts 2400 internal clocks when `rate_hi` is 0 and 1200 when it is 1.
- R6: In an N-clock exact frame, `lrclk` is high for N − floor(N/2) internal clocks, then low. `lrclk` and `frame_start` change only at an enable, or when the prescaler is 00.
- R7: `frame_start` is one master cycle wide and is high exactly on the first cycle in which `lrclk` is high.
- R8: With `freq_mode` 00, a 16-bit accumulator starts at 0 at a setting change and adds `coef` on every enable. A carry out of bit 15 starts a frame. Between frames, `lrclk` is high while the accumulator value is below 0x8000.
- R9: When `freq_mode` is nonzero, the value of `coef` has no effect on frame length.
- R10: A change to `freq_mode`, `rate_hi` or `coef` lets the running frame finish with the old setting. The new setting applies from the next frame boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_sel | input | 2 | Prescaler setting: 00 off, 01 ÷1, 10 ÷2, 11 ÷4 |
| freq_mode | input | 2 | 00 normal (coefficient), 01 12 MHz, 10 13 MHz, 11 19.2 MHz exact |
| rate_hi | input | 1 | Exact modes: 0 selects 8 kHz, 1 selects 16 kHz |
| coef | input | 15 | Normal-mode phase increment |
| pclk_en | output | 1 | Internal clock enable, one master cycle wide |
| lrclk | output | 1 | Frame-rate clock level |
| frame_start | output | 1 | One-cycle pulse at each `lrclk` rising edge |

## Verification
The assertions assume that every exact frame spans at least two internal clocks. They also assume that a normal-mode coefficient is below 0x8000, so that a carry is always preceded by a low `lrclk` phase. The 15-bit port width and the fixed ratio table guarantee both. The stimulus changes its settings only one nanosecond after a rising edge, so the inputs stay steady across each sampled edge. It always uses a nonzero coefficient in normal mode and stays on one setting long enough for at least two full frames before each period is measured.

// File: rtl/cg_pkg.sv
package cg_pkg;

    typedef enum logic [1:0] {
        PS_OFF  = 2'b00,
        PS_DIV1 = 2'b01,
        PS_DIV2 = 2'b10,
        PS_DIV4 = 2'b11
    } psc_sel_e;

    typedef enum logic [1:0] {
        FM_NORMAL = 2'b00,
        FM_12M    = 2'b01,
        FM_13M    = 2'b10,
        FM_19M2   = 2'b11
    } fmode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_EXACT  = 2'b01,
        ST_NORMAL = 2'b10
    } gen_state_e;

    typedef struct packed {
        fmode_e fmode;
        logic   rate_hi;
    } mode_cfg_t;

endpackage

// File: rtl/cg_prescaler.sv
module cg_prescaler
    import cg_pkg::*;
#(
    parameter int PH_W = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  psc_sel_e sel,
    output logic     tick
);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (sel == PS_OFF) begin
            phase <= '0;
        end else begin
            phase <= phase + PH_W'(1);
        end
    end

    always_comb begin
        unique case (sel)
            PS_OFF:  tick = 1'b0;
            PS_DIV1: tick = 1'b1;
            PS_DIV2: tick = phase[0];
            PS_DIV4: tick = &phase[1:0];
            default: tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/cg_frame_ratio.sv
module cg_frame_ratio
    import cg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  mode_cfg_t        cfg,
    input  logic             odd,
    output logic [CNT_W-1:0] len,
    output logic [CNT_W-1:0] hi_len
);

    localparam logic [CNT_W-1:0] R12_SLOW = CNT_W'(1500);
    localparam logic [CNT_W-1:0] R12_FAST = CNT_W'(750);
    localparam logic [CNT_W-1:0] R13_SLOW = CNT_W'(1625);
    localparam logic [CNT_W-1:0] R13_SHORT = CNT_W'(812);
    localparam logic [CNT_W-1:0] R13_LONG = CNT_W'(813);
    localparam logic [CNT_W-1:0] R19_SLOW = CNT_W'(2400);
    localparam logic [CNT_W-1:0] R19_FAST = CNT_W'(1200);

    always_comb begin
        unique case (cfg.fmode)
            FM_12M:  len = cfg.rate_hi ? R12_FAST : R12_SLOW;
            FM_13M:  len = cfg.rate_hi ? (odd ? R13_LONG : R13_SHORT) : R13_SLOW;
            FM_19M2: len = cfg.rate_hi ? R19_FAST : R19_SLOW;
            default: len = '1;
        endcase
    end

    assign hi_len = len - {1'b0, len[CNT_W-1:1]};

endmodule

// File: rtl/codec_frame_clkgen.sv
module codec_frame_clkgen
    import cg_pkg::*;
#(
    parameter int COEF_W = 15,
    parameter int ACC_W  = 16,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        presc_sel,
    input  logic [1:0]        freq_mode,
    input  logic              rate_hi,
    input  logic [COEF_W-1:0] coef,
    output logic              pclk_en,
    output logic              lrclk,
    output logic              frame_start
);

    localparam int SUM_W = ACC_W + 1;

    psc_sel_e          sel;
    mode_cfg_t         live_cfg;
    mode_cfg_t         shd_cfg;
    logic [COEF_W-1:0] shd_coef;
    gen_state_e        state;
    gen_state_e        nxt;
    gen_state_e        run_state;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_inc;
    logic [CNT_W-1:0]  len;
    logic [CNT_W-1:0]  hi_len;
    logic [ACC_W-1:0]  acc;
    logic [SUM_W-1:0]  sum;
    logic              odd;
    logic              tick;
    logic              carry;
    logic              last_cnt;
    logic              bnd;
    logic              cfg_diff;

    assign sel              = psc_sel_e'(presc_sel);
    assign live_cfg.fmode   = fmode_e'(freq_mode);
    assign live_cfg.rate_hi = rate_hi;

    cg_prescaler #(
        .PH_W (2)
    ) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .tick  (tick)
    );

    cg_frame_ratio #(
        .CNT_W (CNT_W)
    ) u_ratio (
        .cfg    (shd_cfg),
        .odd    (odd),
        .len    (len),
        .hi_len (hi_len)
    );

    assign pclk_en  = tick;
    assign sum      = {1'b0, acc} + SUM_W'(shd_coef);
    assign carry    = sum[ACC_W];
    assign cnt_inc  = cnt + CNT_W'(1);
    assign last_cnt = (cnt_inc == len);
    assign run_state = (live_cfg.fmode == FM_NORMAL) ? ST_NORMAL : ST_EXACT;
    assign cfg_diff = (state == ST_IDLE) || (live_cfg != shd_cfg) || (coef != shd_coef);

    always_comb begin
        unique case (state)
            ST_IDLE:   bnd = tick;
            ST_EXACT:  bnd = tick && last_cnt;
            ST_NORMAL: bnd = tick && carry;
            default:   bnd = 1'b0;
        endcase
    end

    always_comb begin
        nxt = state;
        if (sel == PS_OFF) begin
            nxt = ST_IDLE;
        end else if (bnd) begin
            nxt = run_state;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt         <= '0;
            acc         <= '0;
            odd         <= 1'b0;
            lrclk       <= 1'b0;
            frame_start <= 1'b0;
            shd_cfg     <= '0;
            shd_coef    <= '0;
        end else if (sel == PS_OFF) begin
            cnt         <= '0;
            acc         <= '0;
            odd         <= 1'b0;
            lrclk       <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            frame_start <= bnd;
            if (bnd) begin
                cnt   <= '0;
                lrclk <= 1'b1;
                if (cfg_diff) begin
                    shd_cfg  <= live_cfg;
                    shd_coef <= coef;
                    acc      <= '0;
                    odd      <= 1'b0;
                end else begin
                    acc <= sum[ACC_W-1:0];
                    odd <= ~odd;
                end
            end else if (tick) begin
                unique case (state)
                    ST_EXACT: begin
                        cnt   <= cnt_inc;
                        lrclk <= (cnt_inc < hi_len);
                    end
                    ST_NORMAL: begin
                        acc   <= sum[ACC_W-1:0];
                        lrclk <= ~sum[ACC_W-1];
                    end
                    default: begin
                        cnt <= cnt;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/codec_frame_clkgen_chk.sv
module codec_frame_clkgen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] presc_sel,
    input logic       pclk_en,
    input logic       lrclk,
    input logic       frame_start
);

    AST_OFF_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_sel == 2'b00) |-> !pclk_en); // R1

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_sel == 2'b00) |=> (!lrclk && !frame_start)); // R2

    AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (lrclk && !$past(lrclk))); // R7

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start); // R7

    AST_START_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> $past(pclk_en)); // R6

    AST_LR_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrclk) |-> ($past(pclk_en) || ($past(presc_sel) == 2'b00))); // R6

endmodule

bind codec_frame_clkgen codec_frame_clkgen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .presc_sel   (presc_sel),
    .pclk_en     (pclk_en),
    .lrclk       (lrclk),
    .frame_start (frame_start)
);

// File: tb/codec_frame_clkgen_test.sv
`timescale 1ns/1ps
module codec_frame_clkgen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  presc_sel = 2'b00;
    logic [1:0]  freq_mode = 2'b00;
    logic        rate_hi = 1'b0;
    logic [14:0] coef = 15'd0;
    logic        pclk_en;
    logic        lrclk;
    logic        frame_start;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int hi_cnt = 0;
    int last_hi = 0;
    bit done = 0;

    // behavioural reference state
    int m_psc, m_pos, m_len, m_acc, m_fm, m_rt, m_cf;
    bit m_run, m_odd, m_lr, m_fs;

    always #2.5 clk = ~clk;

    codec_frame_clkgen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .presc_sel   (presc_sel),
        .freq_mode   (freq_mode),
        .rate_hi     (rate_hi),
        .coef        (coef),
        .pclk_en     (pclk_en),
        .lrclk       (lrclk),
        .frame_start (frame_start)
    );

    function automatic bit en_rule(int s, int ph);
        case (s)
            1: return 1'b1;
            2: return (ph % 2) == 1;
            3: return ph == 3;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int frame_len(int fm, int rt, bit od);
        case (fm)
            1: return rt ? 750 : 1500;
            2: return rt ? (od ? 813 : 812) : 1625;
            3: return rt ? 1200 : 2400;
            default: return 0;
        endcase
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    always @(posedge clk) begin
        bit tk, bnd, chg;
        if (!rst_n) begin
            m_psc = 0; m_pos = 0; m_len = 0; m_acc = 0;
            m_fm = 0; m_rt = 0; m_cf = 0;
            m_run = 0; m_odd = 0; m_lr = 0; m_fs = 0;
        end else begin
            tk = en_rule(int'(presc_sel), m_psc);
            m_fs = 0;
            if (presc_sel == 2'b00) begin
                m_psc = 0; m_run = 0; m_lr = 0;
            end else begin
                m_psc = (m_psc + 1) % 4;
                if (tk) begin
                    bnd = 0;
                    if (!m_run) begin
                        bnd = 1;
                    end else if (m_fm != 0) begin
                        m_pos++;
                        if (m_pos == m_len) bnd = 1;
                        else m_lr = (m_pos < m_len - m_len / 2);
                    end else begin
                        m_acc += m_cf;
                        if (m_acc >= 65536) begin
                            m_acc -= 65536;
                            bnd = 1;
                        end else begin
                            m_lr = (m_acc < 32768);
                        end
                    end
                    if (bnd) begin
                        chg = !m_run || (int'(freq_mode) != m_fm) ||
                              (int'(rate_hi) != m_rt) || (int'(coef) != m_cf);
                        if (chg) begin
                            m_fm = int'(freq_mode); m_rt = int'(rate_hi); m_cf = int'(coef);
                            m_acc = 0; m_odd = 0;
                        end else begin
                            m_odd = !m_odd;
                        end
                        m_run = 1; m_pos = 0; m_fs = 1; m_lr = 1;
                        m_len = frame_len(m_fm, m_rt, m_odd);
                    end
                end
            end
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(pclk_en === en_rule(int'(presc_sel), m_psc), "R1 pclk_en",
                  int'(pclk_en), int'(en_rule(int'(presc_sel), m_psc)));
            check(lrclk === m_lr, "R6 lrclk", int'(lrclk), int'(m_lr));
            check(frame_start === m_fs, "R7 frame_start", int'(frame_start), int'(m_fs));
        end
    end

    always @(negedge clk) begin
        if (frame_start) begin
            last_hi = hi_cnt;
            hi_cnt = 1;
        end else if (lrclk) begin
            hi_cnt++;
        end
    end

    task automatic drive(int ps, int fm, int rt, int cf, output int at);
        @(posedge clk);
        #1;
        presc_sel = ps[1:0];
        freq_mode = fm[1:0];
        rate_hi = rt[0];
        coef = cf[14:0];
        at = cyc;
    endtask

    task automatic wait_fs(output int stamp);
        do @(negedge clk); while (!frame_start);
        stamp = cyc;
        #1;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        int c, s0, s1, s2, s3, s4, s5, s6, s7, s8, s9, s10, s11, s12;
        int s13, s14, s15, s16, s17, s18, s19, s20, s21, s22, s23, sr;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!lrclk && !frame_start, "R2 reset outputs", int'(lrclk) + int'(frame_start), 0);
        check(!pclk_en, "R1 reset enable", int'(pclk_en), 0);

        // 12 MHz exact, 16 kHz
        drive(1, 1, 1, 'h1234, c);
        wait_fs(s0);
        check(s0 == c + 1, "R2 first frame", s0, c + 1);
        wait_fs(s1);
        check(s1 - s0 == 750, "R3 12M fast", s1 - s0, 750);
        wait_fs(s2);
        check(s2 - s1 == 750, "R3 12M fast", s2 - s1, 750);
        check(last_hi == 375, "R6 high split 750", last_hi, 375);

        // coefficient change in exact mode
        idle(40);
        drive(1, 1, 1, 'h0777, c);
        wait_fs(s3);
        wait_fs(s4);
        check(s3 - s2 == 750, "R9 coef ignored", s3 - s2, 750);
        check(s4 - s3 == 750, "R9 coef ignored", s4 - s3, 750);

        // rate change mid-frame
        idle(100);
        drive(1, 1, 0, 'h0777, c);
        wait_fs(s5);
        check(s5 - s4 == 750, "R10 old frame finishes", s5 - s4, 750);
        wait_fs(s6);
        check(s6 - s5 == 1500, "R3 12M slow", s6 - s5, 1500);

        // 13 MHz, 16 kHz alternation
        idle(100);
        drive(1, 2, 1, 'h0777, c);
        wait_fs(s7);
        check(s7 - s6 == 1500, "R10 old frame finishes", s7 - s6, 1500);
        wait_fs(s8);
        check(s8 - s7 == 812, "R4 first short frame", s8 - s7, 812);
        check(last_hi == 406, "R6 high split 812", last_hi, 406);
        wait_fs(s9);
        check(s9 - s8 == 813, "R4 long frame", s9 - s8, 813);
        check(last_hi == 407, "R6 high split 813", last_hi, 407);
        wait_fs(s10);
        check(s10 - s9 == 812, "R4 short frame", s10 - s9, 812);

        // 13 MHz, 8 kHz
        idle(50);
        drive(1, 2, 0, 'h0777, c);
        wait_fs(s11);
        wait_fs(s12);
        check(s12 - s11 == 1625, "R4 13M slow", s12 - s11, 1625);

        // 19.2 MHz with divide-by-4 prescaler
        idle(50);
        drive(3, 3, 1, 'h0777, c);
        wait_fs(s13);
        wait_fs(s14);
        check(s14 - s13 == 4800, "R5 19M2 fast", s14 - s13, 4800);
        idle(10);
        drive(3, 3, 0, 'h0777, c);
        wait_fs(s15);
        wait_fs(s16);
        check(s16 - s15 == 9600, "R5 19M2 slow", s16 - s15, 9600);

        // normal mode, divide-by-2 prescaler
        idle(10);
        drive(2, 0, 0, 'h1000, c);
        wait_fs(s17);
        wait_fs(s18);
        check(s18 - s17 == 32, "R8 normal period", s18 - s17, 32);
        check(last_hi == 16, "R8 normal half point", last_hi, 16);
        wait_fs(s19);
        check(s19 - s18 == 32, "R8 normal period", s19 - s18, 32);

        // non-integer normal ratio
        idle(3);
        drive(2, 0, 0, 'h3000, c);
        wait_fs(s20);
        wait_fs(s21);
        wait_fs(s22);
        wait_fs(s23);
        check(s23 - s20 == 32, "R8 fractional average", s23 - s20, 32);

        // shutdown and restart
        idle(5);
        drive(0, 0, 0, 'h3000, c);
        @(negedge clk);
        @(negedge clk);
        check(!lrclk && !frame_start, "R2 shutdown outputs", int'(lrclk) + int'(frame_start), 0);
        check(!pclk_en, "R1 shutdown enable", int'(pclk_en), 0);
        idle(20);
        drive(1, 0, 0, 'h3000, c);
        wait_fs(sr);
        check(sr == c + 1, "R2 restart frame", sr, c + 1);
        idle(60);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule